// File: doc/BRIEF.md
# Serial Port Register Controller

This block is the software-facing side of an 8N1 serial port. A 32-bit bus slave with per-byte write enables reaches a small bank of control and status words within a 256-byte window: line control, line status, interrupt enable, interrupt status, FIFO control and baud settings. Characters written by software go into a transmit FIFO, which drains toward a serializer or host link over a valid/ready byte stream. Characters arriving on a receive byte stream fill a receive FIFO, which software empties by reading the receive data word.

Interrupt status flags are raised by hardware from FIFO occupancy: one when receive data is waiting, one when the transmit FIFO has run dry. Software can overwrite them. A single registered level interrupt reports whether any enabled flag is set. Baud timing, flow control, DMA and framing checks are not part of the block. The baud and line-control words are only stored for use by a serializer.

The transmit stream is driven by a two-state machine. `TXS_IDLE` holds `tx_valid` low. The transition *fill* goes to `TXS_OFFER` when the transmit FIFO holds data and no flush is under way. `TXS_OFFER` presents the FIFO head. The transition *drain* returns to `TXS_IDLE` when the last held character is accepted with no push in the same cycle. The transition *flush* returns to `TXS_IDLE` when the transmit FIFO is reset. In every other case `TXS_OFFER` stays put.

Top module: `sio_regblock`

## Requirements
- R1: After reset, line control reads 0x40000000, baud control reads 0x03FF0000, and interrupt enable, FIFO control and line status read 0. `irq` and `tx_valid` are low, `rx_ready` is high, and interrupt status reads 0x00020000 once the first clock edge has passed.
- R2: A write keeps only the writable bits of its register: line control 0xE17F0000, interrupt enable 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000, baud 0x03FF0000. Line status ignores writes.
- R3: `bus_waddr` is the byte offset divided by 4. Byte offset k of a word is lane `bus_be[3-k]`, so `bus_be[3]` covers bits 31:24. A write changes only the enabled lanes, and read data is zero in lanes that are not enabled.
- R4: Word indices other than 0, 1, 2, 3, 4, 5, 8 and 12 read as zero and ignore writes. A write to the receive word (index 12) has no effect.
- R5: A write to index 8 with `bus_be[3]` set pushes `bus_wdata[31:24]` into the transmit FIFO. A write with `bus_be[3]` clear pushes nothing.
- R6: `tx_valid` rises on the second clock edge after a push into an empty FIFO. `tx_data` and `tx_valid` hold while `tx_ready` is low. Each beat with both high drains one character, oldest first.
- R7: `rx_ready` is high exactly when the receive FIFO (FIFO_DEPTH entries) is not full. A read of index 12 with `bus_be[3]` returns the oldest character in bits 31:24 and removes it, or returns 0 when the FIFO is empty. A read without `bus_be[3]` returns 0 and removes nothing.
- R8: Interrupt status bit 16 is set one clock after the receive FIFO is non-empty, and bit 17 one clock after the transmit FIFO is empty. These hardware sets win over a software write in the same cycle.
- R9: A write to interrupt status replaces its writable bits, so writing 0 clears bit 18 and clears bit 17 while the transmit FIFO holds data.
- R10: `irq` is a register that one clock later shows whether any bit of (interrupt status AND interrupt enable) is set. Enable bit 16 is receive, 17 transmit, 18 error and 19 DMA.
- R11: A write to FIFO control whose masked value has bit 16 set empties the receive FIFO if bit 17 is also set, and empties the transmit FIFO if bit 18 is also set. Without bit 16 nothing is emptied.
- R12: A push into a full transmit FIFO is dropped and sets line status bit 18. That overrun bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_waddr | input | 6 | Word index (byte offset / 4) |
| bus_be | input | 4 | Byte lane enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tx_valid | output | 1 | Transmit character offered |
| tx_ready | input | 1 | Transmit character taken |
| tx_data | output | 8 | Transmit character |
| rx_valid | input | 1 | Receive character offered |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Receive character |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. At that depth a full transmit FIFO, a dropped push with its sticky overrun bit, and receive back-pressure on `rx_ready` are each reached in four or five accesses. The depth-independent behaviour is the same as at the default of 16: masks, lanes, flag priority, the interrupt lag and the flush qualifiers.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int WORD_W = 32;
    localparam int CHAR_W = 8;
    localparam int IDX_W  = 6;

    localparam logic [IDX_W-1:0] IDX_LINECTL  = 6'd0;
    localparam logic [IDX_W-1:0] IDX_LINESTAT = 6'd1;
    localparam logic [IDX_W-1:0] IDX_IEN      = 6'd2;
    localparam logic [IDX_W-1:0] IDX_ISTAT    = 6'd3;
    localparam logic [IDX_W-1:0] IDX_FIFOCTL  = 6'd4;
    localparam logic [IDX_W-1:0] IDX_BAUD     = 6'd5;
    localparam logic [IDX_W-1:0] IDX_TXDATA   = 6'd8;
    localparam logic [IDX_W-1:0] IDX_RXDATA   = 6'd12;

    localparam logic [WORD_W-1:0] WMASK_LINECTL = 32'hE17F_0000;
    localparam logic [WORD_W-1:0] WMASK_IEN     = 32'h000F_0000;
    localparam logic [WORD_W-1:0] WMASK_ISTAT   = 32'h0007_0000;
    localparam logic [WORD_W-1:0] WMASK_FIFOCTL = 32'h001F_0000;
    localparam logic [WORD_W-1:0] WMASK_BAUD    = 32'h03FF_0000;

    localparam logic [WORD_W-1:0] RST_LINECTL = 32'h4000_0000;
    localparam logic [WORD_W-1:0] RST_BAUD    = 32'h03FF_0000;

    localparam int BIT_RXFLAG   = 16;
    localparam int BIT_TXFLAG   = 17;
    localparam int BIT_FL_EN    = 16;
    localparam int BIT_FL_RX    = 17;
    localparam int BIT_FL_TX    = 18;
    localparam int BIT_OVERRUN  = 18;

    typedef enum logic [0:0] {
        TXS_IDLE  = 1'b0,
        TXS_OFFER = 1'b1
    } txs_e;

    function automatic logic [WORD_W-1:0] lane_bits(input logic [3:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [3:0]        be,
        input logic [WORD_W-1:0] wmask
    );
        logic [WORD_W-1:0] lm;
        lm = lane_bits(be);
        return wmask & ((old_v & ~lm) | (new_v & lm));
    endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             is_empty, is_full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (count_q == '0);
    assign is_full  = (count_q == CNT_W'(DEPTH));
    assign do_pop   = pop && !is_empty;
    assign do_push  = push && (!is_full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= step(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign dout  = mem[rd_ptr_q];
    assign count = count_q;

    // R12: occupancy never passes the depth
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R11: a flush leaves the FIFO empty
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0));
endmodule

// File: rtl/sio_tx_drain.sv
module sio_tx_drain
    import sio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic have_data,
    input  logic last_beat,
    input  logic take,
    output logic offer
);
    txs_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_IDLE: begin
                if (have_data && !flush) state_d = TXS_OFFER;      // fill
            end
            TXS_OFFER: begin
                if (flush)                   state_d = TXS_IDLE;   // flush
                else if (take && last_beat)  state_d = TXS_IDLE;   // drain
            end
            default: state_d = TXS_IDLE;
        endcase
    end

    always_comb begin
        offer = (state_q == TXS_OFFER);
    end

    // R6: the stream only offers while the FIFO holds a character
    assert_offer_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXS_OFFER) |-> have_data);
endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
    import sio_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_waddr,
    input  logic [3:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              irq
);
    logic [WORD_W-1:0] linectl_q, ien_q, istat_q, fifoctl_q, baud_q;
    logic [WORD_W-1:0] fifoctl_nxt, istat_nxt, hw_set, word_sel;
    logic              ovr_q, irq_q;
    logic              wr_en, rd_en;
    logic              flush_rx, flush_tx;
    logic              tx_push, tx_pop, tx_drop;
    logic              rx_push, rx_pop;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [CHAR_W-1:0] rx_head;
    logic              tx_empty, tx_full, rx_empty, rx_full;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    assign tx_empty = (tx_count == '0);
    assign tx_full  = (tx_count == CNT_W'(FIFO_DEPTH));
    assign rx_empty = (rx_count == '0);
    assign rx_full  = (rx_count == CNT_W'(FIFO_DEPTH));

    // FIFO reset commands act on the value being written
    assign fifoctl_nxt = lane_merge(fifoctl_q, bus_wdata, bus_be, WMASK_FIFOCTL);
    assign flush_rx = wr_en && (bus_waddr == IDX_FIFOCTL) &&
                      fifoctl_nxt[BIT_FL_EN] && fifoctl_nxt[BIT_FL_RX];
    assign flush_tx = wr_en && (bus_waddr == IDX_FIFOCTL) &&
                      fifoctl_nxt[BIT_FL_EN] && fifoctl_nxt[BIT_FL_TX];

    assign tx_push = wr_en && (bus_waddr == IDX_TXDATA) && bus_be[3];
    assign tx_pop  = tx_valid && tx_ready;
    assign tx_drop = tx_push && tx_full && !tx_pop && !flush_tx;

    assign rx_ready = !rx_full;
    assign rx_push  = rx_valid && rx_ready;
    assign rx_pop   = rd_en && (bus_waddr == IDX_RXDATA) && bus_be[3] && !rx_empty;

    sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_tx),
        .push  (tx_push),
        .din   (bus_wdata[WORD_W-1 -: CHAR_W]),
        .pop   (tx_pop),
        .dout  (tx_data),
        .count (tx_count)
    );

    sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_rx),
        .push  (rx_push),
        .din   (rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_count)
    );

    sio_tx_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_tx),
        .have_data (!tx_empty),
        .last_beat ((tx_count == CNT_W'(1)) && !tx_push),
        .take      (tx_pop),
        .offer     (tx_valid)
    );

    // hardware flag sources, taken from registered occupancy
    always_comb begin
        hw_set = '0;
        hw_set[BIT_RXFLAG] = !rx_empty;
        hw_set[BIT_TXFLAG] = tx_empty;
    end

    always_comb begin
        if (wr_en && (bus_waddr == IDX_ISTAT)) begin
            istat_nxt = lane_merge(istat_q, bus_wdata, bus_be, WMASK_ISTAT) | hw_set;
        end else begin
            istat_nxt = istat_q | hw_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            linectl_q <= RST_LINECTL;
            ien_q     <= '0;
            istat_q   <= '0;
            fifoctl_q <= '0;
            baud_q    <= RST_BAUD;
            ovr_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            istat_q <= istat_nxt;
            irq_q   <= |(istat_q & ien_q);
            if (tx_drop) ovr_q <= 1'b1;
            if (wr_en) begin
                case (bus_waddr)
                    IDX_LINECTL: linectl_q <= lane_merge(linectl_q, bus_wdata, bus_be, WMASK_LINECTL);
                    IDX_IEN:     ien_q     <= lane_merge(ien_q, bus_wdata, bus_be, WMASK_IEN);
                    IDX_FIFOCTL: fifoctl_q <= fifoctl_nxt;
                    IDX_BAUD:    baud_q    <= lane_merge(baud_q, bus_wdata, bus_be, WMASK_BAUD);
                    default:     ;
                endcase
            end
        end
    end

    always_comb begin
        word_sel = '0;
        case (bus_waddr)
            IDX_LINECTL:  word_sel = linectl_q;
            IDX_LINESTAT: word_sel[BIT_OVERRUN] = ovr_q;
            IDX_IEN:      word_sel = ien_q;
            IDX_ISTAT:    word_sel = istat_q;
            IDX_FIFOCTL:  word_sel = fifoctl_q;
            IDX_BAUD:     word_sel = baud_q;
            IDX_RXDATA:   if (!rx_empty) word_sel[WORD_W-1 -: CHAR_W] = rx_head;
            default:      word_sel = '0;
        endcase
    end

    assign bus_rdata = word_sel & lane_bits(bus_be);
    assign irq       = irq_q;

    // R10: enabled pending flag shows on irq one clock later
    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(istat_q & ien_q)) |=> irq);
    assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(istat_q & ien_q)) |=> !irq);

    // R12: overrun is sticky
    assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);

    // R8: waiting receive data raises the receive flag
    assert_rx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty |=> istat_q[BIT_RXFLAG]);

    // R6: an unaccepted offer holds its character
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush_tx) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/sio_regblock_bench.sv
module sio_regblock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_waddr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, rx_ready, irq;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data, rx_data = '0;
    int          checks = 0, fails = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    sio_regblock #(.FIFO_DEPTH(4)) u_sio_regblock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_waddr(bus_waddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = idx; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] idx, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = idx; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_be = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        idle(2);
        rd(6'd0, 4'hF, v); chk("R1 line control", v, 32'h4000_0000);
        rd(6'd5, 4'hF, v); chk("R1 baud", v, 32'h03FF_0000);
        rd(6'd2, 4'hF, v); chk("R1 interrupt enable", v, 32'h0);
        rd(6'd4, 4'hF, v); chk("R1 fifo control", v, 32'h0);
        rd(6'd1, 4'hF, v); chk("R1 line status", v, 32'h0);
        rd(6'd3, 4'hF, v); chk("R1 interrupt status", v, 32'h0002_0000);
        chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 1);
    endtask

    task automatic t_write_masks;
        wr(6'd0, 4'hF, 32'hFFFF_FFFF); rd(6'd0, 4'hF, v); chk("R2 line control mask", v, 32'hE17F_0000);
        wr(6'd2, 4'hF, 32'hFFFF_FFFF); rd(6'd2, 4'hF, v); chk("R2 enable mask", v, 32'h000F_0000);
        wr(6'd2, 4'hF, 32'h0);
        wr(6'd4, 4'hF, 32'hFFFF_FFFF); rd(6'd4, 4'hF, v); chk("R2 fifo control mask", v, 32'h001F_0000);
        wr(6'd5, 4'hF, 32'hFFFF_FFFF); rd(6'd5, 4'hF, v); chk("R2 baud mask", v, 32'h03FF_0000);
        wr(6'd1, 4'hF, 32'hFFFF_FFFF); rd(6'd1, 4'hF, v); chk("R2 line status read-only", v, 32'h0);
        wr(6'd3, 4'hF, 32'hFFFF_FFFF); rd(6'd3, 4'hF, v); chk("R2 status mask", v, 32'h0007_0000);
        wr(6'd3, 4'hF, 32'h0);         rd(6'd3, 4'hF, v); chk("R8 tx flag wins over write", v, 32'h0002_0000);
        wr(6'd3, 4'hF, 32'h0004_0000); rd(6'd3, 4'hF, v); chk("R9 error flag set", v, 32'h0006_0000);
        wr(6'd3, 4'hF, 32'h0);         rd(6'd3, 4'hF, v); chk("R9 error flag cleared", v, 32'h0002_0000);
    endtask

    task automatic t_byte_lanes;
        wr(6'd0, 4'hF, 32'h0);
        wr(6'd0, 4'b0100, 32'hFFFF_FFFF); rd(6'd0, 4'hF, v); chk("R3 lane 23:16 only", v, 32'h007F_0000);
        wr(6'd0, 4'b1000, 32'hFFFF_FFFF); rd(6'd0, 4'hF, v); chk("R3 lane 31:24 added", v, 32'hE17F_0000);
        rd(6'd5, 4'b1000, v); chk("R3 read lane mask", v, 32'h0300_0000);
    endtask

    task automatic t_unmapped;
        wr(6'd6, 4'hF, 32'hFFFF_FFFF); rd(6'd6, 4'hF, v); chk("R4 unmapped word", v, 32'h0);
        rd(6'd16, 4'hF, v); chk("R4 unmapped high word", v, 32'h0);
        wr(6'd12, 4'hF, 32'hAB00_0000); rd(6'd12, 4'hF, v); chk("R4 write to receive word ignored", v, 32'h0);
    endtask

    task automatic t_tx_stream;
        tx_ready = 1'b0;
        wr(6'd8, 4'b0111, 32'h1122_3344); idle(3);
        chk("R5 no push without lane 31:24", tx_valid, 0);
        wr(6'd8, 4'b1000, 32'hA500_0000);
        chk("R6 tx_valid not yet", tx_valid, 0);
        @(negedge clk);
        chk("R6 tx_valid on second edge", tx_valid, 1);
        chk("R5 pushed character", tx_data, 32'hA5);
        wr(6'd8, 4'b1000, 32'h5A00_0000); idle(3);
        chk("R6 hold valid", tx_valid, 1);
        chk("R6 hold data", tx_data, 32'hA5);
        tx_ready = 1'b1;
        chk("R6 first beat", tx_data, 32'hA5);
        @(negedge clk);
        chk("R6 second beat valid", tx_valid, 1);
        chk("R6 second beat data", tx_data, 32'h5A);
        @(negedge clk);
        chk("R6 drained", tx_valid, 0);
        tx_ready = 1'b0;
    endtask

    task automatic t_overrun;
        for (int i = 1; i <= 5; i++) wr(6'd8, 4'b1000, {8'(i), 24'h0});
        rd(6'd1, 4'hF, v); chk("R12 overrun set", v, 32'h0004_0000);
        tx_ready = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            chk("R12 kept entry valid", tx_valid, 1);
            chk("R12 kept entry data", tx_data, 32'(i));
            @(negedge clk);
        end
        chk("R12 fifth push dropped", tx_valid, 0);
        tx_ready = 1'b0;
        rd(6'd1, 4'hF, v); chk("R12 overrun sticky", v, 32'h0004_0000);
    endtask

    task automatic t_tx_flag_and_flush;
        wr(6'd8, 4'b1000, 32'h7700_0000);
        wr(6'd3, 4'hF, 32'h0); rd(6'd3, 4'hF, v); chk("R9 tx flag cleared while data held", v, 32'h0);
        wr(6'd4, 4'hF, 32'h0005_0000);
        chk("R11 tx flush drops offer", tx_valid, 0);
        idle(2);
        rd(6'd3, 4'hF, v); chk("R8 tx flag after flush", v, 32'h0002_0000);
    endtask

    task automatic t_rx_path;
        for (int i = 0; i < 4; i++) rx_send(8'h31 + 8'(i));
        chk("R7 rx_ready low when full", rx_ready, 0);
        rd(6'd3, 4'hF, v); chk("R8 rx flag set", v, 32'h0003_0000);
        rd(6'd12, 4'b0111, v); chk("R7 other lanes read zero", v, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(6'd12, 4'b1000, v); chk("R7 oldest first", v, {8'h31 + 8'(i), 24'h0});
        end
        rd(6'd12, 4'b1000, v); chk("R7 empty reads zero", v, 32'h0);
        chk("R7 rx_ready high", rx_ready, 1);
    endtask

    task automatic t_rx_flush;
        rx_send(8'h41); rx_send(8'h42);
        wr(6'd4, 4'hF, 32'h0002_0000);
        rd(6'd12, 4'b1000, v); chk("R11 no flush without enable", v, 32'h4100_0000);
        wr(6'd4, 4'hF, 32'h0003_0000);
        rd(6'd12, 4'b1000, v); chk("R11 rx flushed", v, 32'h0);
    endtask

    task automatic t_interrupt;
        wr(6'd3, 4'hF, 32'h0);
        wr(6'd2, 4'hF, 32'h0001_0000); idle(2);
        chk("R10 no irq without pending", irq, 0);
        rx_send(8'h55); idle(3);
        chk("R10 irq on rx data", irq, 1);
        rd(6'd12, 4'b1000, v); chk("R7 pop irq byte", v, 32'h5500_0000);
        idle(2);
        chk("R10 irq held by sticky flag", irq, 1);
        wr(6'd3, 4'hF, 32'h0);
        chk("R10 irq lags clear by one clock", irq, 1);
        @(negedge clk);
        chk("R10 irq cleared", irq, 0);
        wr(6'd2, 4'hF, 32'h0002_0000);
        chk("R10 irq lags enable", irq, 0);
        @(negedge clk);
        chk("R10 irq on tx empty", irq, 1);
        wr(6'd2, 4'hF, 32'h0);
        @(negedge clk);
        chk("R10 irq off after disable", irq, 0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write_masks();
        t_byte_lanes();
        t_unmapped();
        t_tx_stream();
        t_overrun();
        t_tx_flag_and_flush();
        t_rx_path();
        t_rx_flush();
        t_interrupt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule